// File: doc/BRIEF.md
# DMA Channel Event Front End

This block sits in front of the transfer engine of a 64-channel DMA controller. Each channel has a synchronous event line from a peripheral. A pulse on that line is latched as a pending bit. A pending bit goes forward only when the channel's enable bit is set. Enabled channels are admitted one at a time into a single-entry request slot, which a transfer engine drains over a valid/ready handshake. Admitting a channel marks it in-flight. The in-flight mark stays until the engine reports completion or software removes it. While it stands, later events on that channel wait as pending. If yet another event arrives on top of that, the event is lost and the channel's missed flag is raised.

Software sees the four per-channel state vectors (pending, enable, in-flight, missed) through a small word-wide register bus. Each vector is split into a low half (channels 0 to 31) and a high half (channels 32 to 63). Software can also raise a pending bit by hand, and can clear pending, in-flight and missed bits. A channel with its missed flag set is frozen until software recovers it: clear in-flight first, then clear missed.

Top module: `dmaev_front`

## Requirements
- R1: After reset every register reads zero and `req_valid` is low. An `evt_in[n]` pulse sets bit n mod 32 of the pending register of half n/32. For example, channel 52 reads as 0x00100000 in the high half.
- R2: A pending channel whose enable bit is clear stays pending and produces no request.
- R3: A channel that is pending, enabled, and neither in-flight nor missed is admitted. `req_valid` rises at the second clock edge after the event pulse, with `req_chan` = n. Its pending bit clears and its in-flight bit sets.
- R4: An in-flight channel is never admitted. A second event during that time stays pending without raising missed. A third event, arriving while the channel is both in-flight and pending, sets the missed bit.
- R5: While missed is set the channel is not admitted. A single write-1-to-clear of in-flight makes it read zero even with missed set. A later clear of missed lets the pending event be admitted.
- R6: A `done_valid` pulse with `done_chan` = n clears n's in-flight bit. A pending, enabled channel n is then admitted, and its request appears one edge later.
- R7: Writing 1 to a bit of the pending-set register triggers that channel exactly as a pin event does.
- R8: Set and clear registers act only on bits written as 1. Zero bits leave state unchanged.
- R9: Among ready channels the lowest-numbered one is admitted first. While `req_valid` is high and `req_ready` is low, `req_valid` and `req_chan` hold, and nothing further is admitted.
- R10: An event and a software clear of the same pending bit in one cycle leave the bit set.
- R11: The register address is {sel[2:0], half}, where half 0 is channels 0 to 31 and half 1 is channels 32 to 63. The sel codes are: 0 pending (read), 1 pending-set, 2 pending-clear, 3 enable (read/write), 4 in-flight (read), 5 in-flight-clear, 6 missed (read), 7 missed-clear. Reads of write-only codes return 0. Reads are combinational, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 64 | Per-channel synchronous event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address {sel, half} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| req_valid | output | 1 | Request slot holds an admitted channel |
| req_ready | input | 1 | Transfer engine takes the request |
| req_chan | output | 6 | Channel number of the request |
| done_valid | input | 1 | Transfer completion strobe |
| done_chan | input | 6 | Channel that completed |

## Verification
The bench goes after the in-flight window, in which a design can go wrong in several ways:
- Admitting a second pulse at once would put a duplicate channel into the scoreboard.
- Dropping the second pulse would leave the pending read at zero.
- Setting missed on the second pulse instead of the third would be caught by the missed readback.

Recovery is checked in order. A design that re-admits while missed is still set gives an unexpected request. One whose in-flight clear does not stick reads back nonzero.

Arbitration is checked with simultaneous events on channels 0, 3 and 33 while the engine stalls. A design with the wrong priority, or one that changes `req_chan` under backpressure, fails the ordered scoreboard.

Finally, an event and a clear of the same pending bit are driven in the same cycle. If the clear wins, the pending bit reads as lost.

// File: rtl/dmaev_pkg.sv
package dmaev_pkg;

    // register selector codes, upper bits of the bus address
    typedef enum logic [2:0] {
        RS_PEND  = 3'd0,
        RS_PSET  = 3'd1,
        RS_PCLR  = 3'd2,
        RS_ENA   = 3'd3,
        RS_INFL  = 3'd4,
        RS_ICLR  = 3'd5,
        RS_MISS  = 3'd6,
        RS_MCLR  = 3'd7
    } reg_sel_e;

    localparam int unsigned SEL_W  = 3;
    localparam int unsigned ADDR_W = SEL_W + 1;

    // decoded bus access
    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        logic     half;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_cmd(input logic wr, input logic [ADDR_W-1:0] addr);
        bus_cmd_t c;
        c.wr   = wr;
        c.sel  = reg_sel_e'(addr[ADDR_W-1:1]);
        c.half = addr[0];
        return c;
    endfunction

endpackage

// File: rtl/dmaev_bank.sv
module dmaev_bank
    import dmaev_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] pset,
    input  logic [W-1:0] pclr,
    input  logic         ena_wr,
    input  logic [W-1:0] ena_wdata,
    input  logic [W-1:0] iclr,
    input  logic [W-1:0] mclr,
    input  logic [W-1:0] done_clr,
    input  logic [W-1:0] admit,
    output logic [W-1:0] pend,
    output logic [W-1:0] ena,
    output logic [W-1:0] infl,
    output logic [W-1:0] miss,
    output logic [W-1:0] ready
);

    logic [W-1:0] ev;
    logic [W-1:0] lost;

    assign ev    = hit | pset;
    // event lost: channel busy and a request already waiting
    assign lost  = ev & infl & pend;
    assign ready = pend & ena & ~infl & ~miss;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ena  <= '0;
            infl <= '0;
            miss <= '0;
        end else begin
            pend <= ev | (pend & ~pclr & ~admit);
            infl <= admit | (infl & ~iclr & ~done_clr);
            miss <= lost | (miss & ~mclr);
            if (ena_wr) ena <= ena_wdata;
        end
    end

    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (admit & ~ena) == '0);

    p_block_r4: assert property (@(posedge clk) disable iff (rst)
        (admit & (infl | miss)) == '0);

    p_admit_marks_r3: assert property (@(posedge clk) disable iff (rst)
        (|admit) |=> (((infl & $past(admit)) == $past(admit)) &&
                      ((pend & $past(admit & ~ev)) == '0)));

    p_third_sets_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (|lost) |=> ((miss & $past(lost)) == $past(lost)));

    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((pend & $past(ev)) == $past(ev)));

endmodule

// File: rtl/dmaev_arbiter.sv
module dmaev_arbiter
    import dmaev_pkg::*;
#(
    parameter int unsigned CH_NUM = 64,
    localparam int unsigned CH_W  = $clog2(CH_NUM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_NUM-1:0] ready,
    input  logic              req_ready,
    output logic [CH_NUM-1:0] admit,
    output logic              req_valid,
    output logic [CH_W-1:0]   req_chan
);

    logic            load_ok;
    logic            found;
    logic [CH_W-1:0] pick;

    assign load_ok = ~req_valid | req_ready;

    // lowest index wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < int'(CH_NUM); i++) begin
            if (ready[i] && !found) begin
                found = 1'b1;
                pick  = CH_W'(i);
            end
        end
    end

    always_comb begin
        admit = '0;
        if (found && load_ok) admit[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_chan  <= '0;
        end else if (found && load_ok) begin
            req_valid <= 1'b1;
            req_chan  <= pick;
        end else if (req_ready) begin
            req_valid <= 1'b0;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_chan)));

    p_single_admit_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(admit));

    p_stall_no_admit_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |-> (admit == '0));

endmodule

// File: rtl/dmaev_regbus.sv
module dmaev_regbus
    import dmaev_pkg::*;
#(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned CH_NUM = 2 * HALF_W
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    input  logic [CH_NUM-1:0] pend,
    input  logic [CH_NUM-1:0] ena,
    input  logic [CH_NUM-1:0] infl,
    input  logic [CH_NUM-1:0] miss,
    output logic [CH_NUM-1:0] pset,
    output logic [CH_NUM-1:0] pclr,
    output logic [CH_NUM-1:0] iclr,
    output logic [CH_NUM-1:0] mclr,
    output logic [1:0]        ena_wr,
    output logic [HALF_W-1:0] ena_wdata
);

    bus_cmd_t cmd;
    assign cmd       = decode_cmd(bus_wr, bus_addr);
    assign ena_wdata = bus_wdata;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic hit_h;
        assign hit_h = cmd.wr && (cmd.half == 1'(h));
        assign pset[h*HALF_W +: HALF_W] = (hit_h && cmd.sel == RS_PSET) ? bus_wdata : '0;
        assign pclr[h*HALF_W +: HALF_W] = (hit_h && cmd.sel == RS_PCLR) ? bus_wdata : '0;
        assign iclr[h*HALF_W +: HALF_W] = (hit_h && cmd.sel == RS_ICLR) ? bus_wdata : '0;
        assign mclr[h*HALF_W +: HALF_W] = (hit_h && cmd.sel == RS_MCLR) ? bus_wdata : '0;
        assign ena_wr[h] = hit_h && cmd.sel == RS_ENA;
    end

    function automatic logic [HALF_W-1:0] slice(input logic [CH_NUM-1:0] v, input logic h);
        return h ? v[CH_NUM-1:HALF_W] : v[HALF_W-1:0];
    endfunction

    always_comb begin
        unique case (cmd.sel)
            RS_PEND: bus_rdata = slice(pend, cmd.half);
            RS_ENA:  bus_rdata = slice(ena,  cmd.half);
            RS_INFL: bus_rdata = slice(infl, cmd.half);
            RS_MISS: bus_rdata = slice(miss, cmd.half);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmaev_front.sv
module dmaev_front
    import dmaev_pkg::*;
#(
    parameter int unsigned CH_NUM = 64,
    localparam int unsigned HALF_W = CH_NUM / 2,
    localparam int unsigned CH_W   = $clog2(CH_NUM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_NUM-1:0] evt_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [CH_W-1:0]   req_chan,
    input  logic              done_valid,
    input  logic [CH_W-1:0]   done_chan
);

    logic [CH_NUM-1:0] pend, ena, infl, miss, ready;
    logic [CH_NUM-1:0] pset, pclr, iclr, mclr, admit, done_clr;
    logic [1:0]        ena_wr;
    logic [HALF_W-1:0] ena_wdata;

    assign done_clr = done_valid ? ({{(CH_NUM-1){1'b0}}, 1'b1} << done_chan) : '0;

    dmaev_regbus #(.HALF_W(HALF_W)) u_regbus (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (pend),
        .ena       (ena),
        .infl      (infl),
        .miss      (miss),
        .pset      (pset),
        .pclr      (pclr),
        .iclr      (iclr),
        .mclr      (mclr),
        .ena_wr    (ena_wr),
        .ena_wdata (ena_wdata)
    );

    for (genvar h = 0; h < 2; h++) begin : g_bank
        dmaev_bank #(.W(HALF_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .hit       (evt_in  [h*HALF_W +: HALF_W]),
            .pset      (pset    [h*HALF_W +: HALF_W]),
            .pclr      (pclr    [h*HALF_W +: HALF_W]),
            .ena_wr    (ena_wr[h]),
            .ena_wdata (ena_wdata),
            .iclr      (iclr    [h*HALF_W +: HALF_W]),
            .mclr      (mclr    [h*HALF_W +: HALF_W]),
            .done_clr  (done_clr[h*HALF_W +: HALF_W]),
            .admit     (admit   [h*HALF_W +: HALF_W]),
            .pend      (pend    [h*HALF_W +: HALF_W]),
            .ena       (ena     [h*HALF_W +: HALF_W]),
            .infl      (infl    [h*HALF_W +: HALF_W]),
            .miss      (miss    [h*HALF_W +: HALF_W]),
            .ready     (ready   [h*HALF_W +: HALF_W])
        );
    end

    dmaev_arbiter #(.CH_NUM(CH_NUM)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .ready     (ready),
        .req_ready (req_ready),
        .admit     (admit),
        .req_valid (req_valid),
        .req_chan  (req_chan)
    );

    p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (done_valid && infl[done_chan]) |=> !infl[$past(done_chan)] || req_valid);

endmodule

// File: tb/dmaev_front_tb_top.sv
module dmaev_front_tb_top;
    import dmaev_pkg::*;

    localparam int unsigned CLK_P = 10;
    localparam int unsigned NCH   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] evt_in = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [5:0]  req_chan;
    logic        done_valid = 1'b0;
    logic [5:0]  done_chan = '0;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    dmaev_front #(.CH_NUM(NCH)) dut_i (
        .clk(clk), .rst(rst), .evt_in(evt_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
        .done_valid(done_valid), .done_chan(done_chan)
    );

    function automatic logic [3:0] ad(input reg_sel_e s, input bit h);
        return {s, h};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: a handshake seen mid-cycle completes at the next edge
    always @(negedge clk) begin
        if (!rst && !finished && req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected request", req_chan, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(req_chan == 6'(e), "R9 request channel order", req_chan, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        @(negedge clk);
        chk(bus_rdata == e, tag, bus_rdata, e);
    endtask

    task automatic pulse(input int ch);
        evt_in[ch] = 1'b1;
        tick();
        evt_in = '0;
    endtask

    task automatic done(input int ch);
        done_valid = 1'b1; done_chan = 6'(ch);
        tick();
        done_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        ticks(3);
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(ad(RS_PEND, 0), 0, "R1 reset pend lo");
        rd(ad(RS_PEND, 1), 0, "R1 reset pend hi");
        rd(ad(RS_INFL, 1), 0, "R1 reset infl hi");
        rd(ad(RS_MISS, 0), 0, "R1 reset miss lo");
        chk(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);

        // R1/R2 latch with enable clear
        pulse(52);
        rd(ad(RS_PEND, 1), 32'h0010_0000, "R1 ch52 pending hi");
        ticks(4);
        rd(ad(RS_PEND, 1), 32'h0010_0000, "R2 disabled stays pending");
        rd(ad(RS_INFL, 1), 0, "R2 disabled not in flight");

        // R3 admission after enabling; R11 enable readback
        exp_q.push_back(52);
        wr(ad(RS_ENA, 1), 32'h0010_0000);
        rd(ad(RS_ENA, 1), 32'h0010_0000, "R11 enable readback");
        ticks(3);
        rd(ad(RS_PEND, 1), 0, "R3 pending cleared on admit");
        rd(ad(RS_INFL, 1), 32'h0010_0000, "R3 in-flight set on admit");
        rd(ad(RS_PSET, 1), 0, "R11 write-only reads zero");

        // R4 second event waits, third is missed
        pulse(52);
        ticks(2);
        rd(ad(RS_PEND, 1), 32'h0010_0000, "R4 second event pending");
        rd(ad(RS_MISS, 1), 0, "R4 second event no miss");
        pulse(52);
        ticks(2);
        rd(ad(RS_MISS, 1), 32'h0010_0000, "R4 third event missed");

        // R5 recovery sequence
        for (int k = 0; k < 4; k++) wr(ad(RS_ICLR, 1), 32'h0010_0000);
        ticks(3);
        rd(ad(RS_INFL, 1), 0, "R5 in-flight cleared while missed");
        rd(ad(RS_PEND, 1), 32'h0010_0000, "R5 blocked while missed");
        exp_q.push_back(52);
        wr(ad(RS_MCLR, 1), 32'h0010_0000);
        ticks(3);
        rd(ad(RS_MISS, 1), 0, "R5 missed cleared");
        rd(ad(RS_INFL, 1), 32'h0010_0000, "R5 readmitted");

        // R6 completion releases pending event
        pulse(52);
        ticks(2);
        exp_q.push_back(52);
        done(52);
        ticks(3);
        rd(ad(RS_PEND, 1), 0, "R6 pending admitted after done");
        rd(ad(RS_INFL, 1), 32'h0010_0000, "R6 in flight again");
        done(52);
        rd(ad(RS_INFL, 1), 0, "R6 done clears in-flight");

        // R7 software trigger
        wr(ad(RS_ENA, 0), 32'h0000_0009);
        exp_q.push_back(3);
        wr(ad(RS_PSET, 0), 32'h0000_0008);
        ticks(3);
        rd(ad(RS_INFL, 0), 32'h0000_0008, "R7 software trigger admitted");
        done(3);

        // R9 priority and backpressure
        wr(ad(RS_ENA, 1), 32'h0010_0002);
        req_ready = 1'b0;
        exp_q.push_back(0); exp_q.push_back(3); exp_q.push_back(33);
        evt_in[0] = 1'b1; evt_in[3] = 1'b1; evt_in[33] = 1'b1;
        tick();
        evt_in = '0;
        tick();
        @(negedge clk);
        chk(req_valid && req_chan == 6'd0, "R9 lowest first", req_chan, 0);
        ticks(3);
        @(negedge clk);
        chk(req_valid && req_chan == 6'd0, "R9 held under stall", req_chan, 0);
        rd(ad(RS_PEND, 0), 32'h0000_0008, "R9 ch3 waits in stall");
        req_ready = 1'b1;
        ticks(5);
        done(0); done(3); done(33);
        rd(ad(RS_INFL, 0), 0, "R9 all done lo");

        // R8 zero bits have no effect
        wr(ad(RS_ENA, 0), 0);
        pulse(5); pulse(6);
        wr(ad(RS_PCLR, 0), 0);
        rd(ad(RS_PEND, 0), 32'h0000_0060, "R8 clear with zeros");
        wr(ad(RS_PCLR, 0), 32'h0000_0020);
        rd(ad(RS_PEND, 0), 32'h0000_0040, "R8 clear selected bit");
        wr(ad(RS_PSET, 0), 0);
        rd(ad(RS_PEND, 0), 32'h0000_0040, "R8 set with zeros");

        // R10 event beats clear
        evt_in[6] = 1'b1;
        wr(ad(RS_PCLR, 0), 32'h0000_0040);
        evt_in = '0;
        rd(ad(RS_PEND, 0), 32'h0000_0040, "R10 event wins over clear");
        wr(ad(RS_PCLR, 0), 32'h0000_0040);
        rd(ad(RS_PEND, 0), 0, "R10 clear alone works");

        ticks(3);
        chk(exp_q.size() == 0, "R3 all expected requests seen", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule